// File: doc/BRIEF.md
# SPI Status and Interrupt Unit

This block sits beside an SPI serial engine and its receive and transmit FIFOs. It turns the engine's condition signals into one 16-bit status word. Two kinds of condition feed it. Level conditions come from FIFO occupancy and follow their inputs directly. Event conditions arrive as one-cycle pulses and are latched into sticky flags, which stay set until software clears them.

Software selects which conditions may interrupt through an enable register. It clears sticky flags by writing ones to a flag-clear port. A single interrupt line is raised while any enabled condition is present.

One enable bit serves three completion-type events: end of transfer, suspension and transmission complete. When the engine signals that the whole transfer has been loaded into the transmit path, the unit drops the packet-driven enables by itself. The unit also gates the DMA request lines: a pending mode fault stops both DMA requests and signals an abort, and a pending overrun tells the engine to drop incoming data.

Top module: `spi_stat_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, every sticky flag and every enable bit is 0. The interrupt, abort and drop outputs are then low.
- R2: Status bit 0 follows the RX-packet level, bit 1 follows the TX-space level, and bit 2 is set when both are set. Bits 14:13 show the RX partial level and bit 15 shows RX word-not-empty. All of these change in the same cycle as their inputs. Writes to the clear port have no effect on them.
- R3: An event pulse sets its sticky flag from the next cycle on, and the flag then holds. The flag positions are: end of transfer bit 3, transfer-filled bit 4, transmission complete bit 5, overrun bit 6, mode fault bit 9, suspended bit 11.
- R4: A clear-port write with a one in any of bits 11:3 clears the matching sticky flag in the next cycle. Flags written with zero keep their value. If an event and a clear for the same flag land in the same cycle, the event wins.
- R5: The enable register keeps only bits 0, 1, 2, 3, 4, 6 and 9. All other bits read 0.
- R6: The interrupt is high when any enabled source is set. Enable bits 0, 1, 2, 4, 6 and 9 cover the status bits of the same index. Enable bit 3 covers status bits 3, 5 and 11.
- R7: A transfer-filled event clears enable bits 1 and 2 in the next cycle, overriding any enable write in the same cycle. The other enable bits are left as they are.
- R8: While the mode-fault flag is set, the abort output is high and both DMA requests are low.
- R9: The drop output is high exactly while the overrun flag is set.
- R10: The TX DMA request is the TX DMA enable AND the TX-space level. The RX DMA request is the RX DMA enable AND the RX-packet level. Both apply only when no mode fault is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_pkt_i | input | 1 | RX FIFO holds a full packet (level) |
| tx_space_i | input | 1 | TX FIFO has room for a packet (level) |
| rx_part_lvl_i | input | 2 | Frames in the last partial RX word (level) |
| rx_word_ne_i | input | 1 | RX FIFO holds at least one word (level) |
| eot_ev_i | input | 1 | End-of-transfer pulse |
| susp_ev_i | input | 1 | Suspension pulse |
| txc_ev_i | input | 1 | Transmission-complete pulse |
| txtf_ev_i | input | 1 | Transfer fully loaded into TX path pulse |
| ovr_ev_i | input | 1 | Overrun pulse |
| modf_ev_i | input | 1 | Mode-fault pulse |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 16 | Enable register write data |
| clr_we_i | input | 1 | Flag-clear write strobe |
| clr_wdata_i | input | 16 | Flag-clear data, one bit per flag |
| txdma_en_i | input | 1 | TX DMA enable |
| rxdma_en_i | input | 1 | RX DMA enable |
| status_o | output | 16 | Status word |
| ier_o | output | 16 | Enable register readback |
| irq_o | output | 1 | Interrupt request |
| tx_dma_req_o | output | 1 | Gated TX DMA request |
| rx_dma_req_o | output | 1 | Gated RX DMA request |
| xfer_abort_o | output | 1 | Abort the transfer (mode fault pending) |
| rx_drop_o | output | 1 | Discard incoming data (overrun pending) |

## Verification
The hardest case to reach is a collision between a software write and a hardware update in the same cycle. One form is an event pulse arriving together with a clear of the same flag. The other is a transfer-filled pulse arriving together with an enable write that sets the packet enables. The stimulus creates both collisions by raising the event and the write strobe at the same falling edge. It then reads the flag or the enable register after the next rising edge, where the hardware update must have won. The stimulus also steps through each of the three completion events with only the end-of-transfer enable set, to show that the one shared enable covers all three.

// File: rtl/spi_stat_pkg.sv
// Shared constants for the SPI status and interrupt unit.
// Bit positions are fixed because software decodes them.
package spi_stat_pkg;
    localparam int STAT_W  = 16;
    localparam int LVL_W   = 2;
    localparam int B_RXP   = 0;
    localparam int B_TXP   = 1;
    localparam int B_DXP   = 2;
    localparam int B_EOT   = 3;
    localparam int B_TXTF  = 4;
    localparam int B_TXC   = 5;
    localparam int B_OVR   = 6;
    localparam int B_MODF  = 9;
    localparam int B_SUSP  = 11;
    localparam int B_LVL   = 13;
    localparam int B_WNE   = 15;
    localparam int CLR_LO  = 3;
    localparam int CLR_HI  = 11;

    localparam logic [STAT_W-1:0] IER_MASK =
        STAT_W'((1 << B_RXP) | (1 << B_TXP) | (1 << B_DXP) | (1 << B_EOT) |
                (1 << B_TXTF) | (1 << B_OVR) | (1 << B_MODF));
    localparam logic [STAT_W-1:0] STICKY_MASK =
        STAT_W'((1 << B_EOT) | (1 << B_TXTF) | (1 << B_TXC) |
                (1 << B_OVR) | (1 << B_MODF) | (1 << B_SUSP));
    localparam logic [STAT_W-1:0] CLR_WIN =
        STAT_W'(((1 << (CLR_HI + 1)) - 1) & ~((1 << CLR_LO) - 1));
    localparam logic [STAT_W-1:0] AUTO_CLR =
        STAT_W'((1 << B_TXP) | (1 << B_DXP));
endpackage

// File: rtl/spi_stat_flags.sv
// Sticky event flags. Only the bits selected by KEEP hold state; all others read 0.
// Assumes set_i carries one-cycle pulses. A set in the same cycle as a clear wins.
module spi_stat_flags #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    KEEP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_q;
    logic [W-1:0] q_d;

    // Next state: keep, add new events, drop cleared bits not being set now.
    always_comb begin
        q_d = ((q_q | set_i) & ~(clr_i & ~set_i)) & KEEP;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/spi_stat_ier.sv
// Interrupt-enable register. Only bits in MASK are writable.
// A transfer-filled event clears the AUTO bits and overrides a same-cycle write.
module spi_stat_ier #(
    parameter int           W    = 16,
    parameter logic [W-1:0] MASK = '0,
    parameter logic [W-1:0] AUTO = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         auto_clr_i,
    output logic [W-1:0] ier_o
);
    logic [W-1:0] ier_q;
    logic [W-1:0] ier_d;
    logic [W-1:0] kill;

    // Select the written value, then apply the auto-clear.
    always_comb begin
        kill  = auto_clr_i ? AUTO : '0;
        ier_d = ((we_i ? wdata_i : ier_q) & MASK) & ~kill;
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ier_q <= '0;
        else        ier_q <= ier_d;
    end

    assign ier_o = ier_q;
endmodule

// File: rtl/spi_stat_irq.sv
// Interrupt combiner. Builds one source per enable bit from the status word and ORs the enabled ones.
// The EOT_BIT source also covers the suspend and transmission-complete flags.
module spi_stat_irq #(
    parameter int           W        = 16,
    parameter logic [W-1:0] MASK     = '0,
    parameter int           EOT_BIT  = 3,
    parameter int           SUSP_BIT = 11,
    parameter int           TXC_BIT  = 5
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] ier_i,
    output logic         irq_o
);
    logic [W-1:0] src;

    // One source per enable bit; the shared completion enable gets three inputs.
    for (genvar g = 0; g < W; g++) begin : g_src
        if (g == EOT_BIT) begin : g_shared
            assign src[g] = status_i[EOT_BIT] | status_i[SUSP_BIT] | status_i[TXC_BIT];
        end else begin : g_plain
            assign src[g] = status_i[g];
        end
    end

    // Request when any enabled source is present.
    always_comb begin
        irq_o = |(src & ier_i & MASK);
    end
endmodule

// File: rtl/spi_stat_irq_unit.sv
// SPI status and interrupt unit (top).
// Merges live FIFO levels and sticky engine events into the status word.
// Drives the interrupt line and gates DMA requests and engine control.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module spi_stat_irq_unit
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_pkt_i,
    input  logic              tx_space_i,
    input  logic [LVL_W-1:0]  rx_part_lvl_i,
    input  logic              rx_word_ne_i,
    input  logic              eot_ev_i,
    input  logic              susp_ev_i,
    input  logic              txc_ev_i,
    input  logic              txtf_ev_i,
    input  logic              ovr_ev_i,
    input  logic              modf_ev_i,
    input  logic              ier_we_i,
    input  logic [STAT_W-1:0] ier_wdata_i,
    input  logic              clr_we_i,
    input  logic [STAT_W-1:0] clr_wdata_i,
    input  logic              txdma_en_i,
    input  logic              rxdma_en_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] ier_o,
    output logic              irq_o,
    output logic              tx_dma_req_o,
    output logic              rx_dma_req_o,
    output logic              xfer_abort_o,
    output logic              rx_drop_o
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] sticky;
    logic [STAT_W-1:0] stat;

    // Place each event pulse at its flag position.
    always_comb begin
        set_vec          = '0;
        set_vec[B_EOT]   = eot_ev_i;
        set_vec[B_TXTF]  = txtf_ev_i;
        set_vec[B_TXC]   = txc_ev_i;
        set_vec[B_OVR]   = ovr_ev_i;
        set_vec[B_MODF]  = modf_ev_i;
        set_vec[B_SUSP]  = susp_ev_i;
    end

    // Clear requests, limited to the clearable window.
    always_comb begin
        clr_vec = clr_we_i ? (clr_wdata_i & CLR_WIN) : '0;
    end

    spi_stat_flags #(
        .W    (STAT_W),
        .KEEP (STICKY_MASK)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (sticky)
    );

    // Merge the sticky flags with the live levels.
    always_comb begin
        stat                        = sticky;
        stat[B_RXP]                 = rx_pkt_i;
        stat[B_TXP]                 = tx_space_i;
        stat[B_DXP]                 = rx_pkt_i & tx_space_i;
        stat[B_LVL +: LVL_W]        = rx_part_lvl_i;
        stat[B_WNE]                 = rx_word_ne_i;
    end

    spi_stat_ier #(
        .W    (STAT_W),
        .MASK (IER_MASK),
        .AUTO (AUTO_CLR)
    ) u_ier (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (ier_we_i),
        .wdata_i    (ier_wdata_i),
        .auto_clr_i (txtf_ev_i),
        .ier_o      (ier_o)
    );

    spi_stat_irq #(
        .W        (STAT_W),
        .MASK     (IER_MASK),
        .EOT_BIT  (B_EOT),
        .SUSP_BIT (B_SUSP),
        .TXC_BIT  (B_TXC)
    ) u_irq (
        .status_i (stat),
        .ier_i    (ier_o),
        .irq_o    (irq_o)
    );

    // Engine control and DMA gating from the pending faults.
    always_comb begin
        xfer_abort_o = sticky[B_MODF];
        rx_drop_o    = sticky[B_OVR];
        tx_dma_req_o = txdma_en_i & tx_space_i & ~sticky[B_MODF];
        rx_dma_req_o = rxdma_en_i & rx_pkt_i   & ~sticky[B_MODF];
    end

    assign status_o = stat;
endmodule

// File: rtl/spi_stat_irq_unit_chk.sv
// Checker for spi_stat_irq_unit. It is bound to the top and observes only the top's ports.
module spi_stat_irq_unit_chk
    import spi_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_pkt_i,
    input logic              tx_space_i,
    input logic              eot_ev_i,
    input logic              modf_ev_i,
    input logic              ovr_ev_i,
    input logic              txtf_ev_i,
    input logic              clr_we_i,
    input logic [STAT_W-1:0] clr_wdata_i,
    input logic              txdma_en_i,
    input logic [STAT_W-1:0] status_o,
    input logic [STAT_W-1:0] ier_o,
    input logic              irq_o,
    input logic              tx_dma_req_o,
    input logic              rx_dma_req_o,
    input logic              xfer_abort_o,
    input logic              rx_drop_o
);
    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |=> (ier_o == '0 && (status_o & STICKY_MASK) == '0 && !irq_o));

    assert_dxp_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[B_DXP] == (rx_pkt_i && tx_space_i));

    assert_modf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        modf_ev_i |=> status_o[B_MODF]);

    assert_eot_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_wdata_i[B_EOT] && !eot_ev_i) |=> !status_o[B_EOT]);

    assert_ier_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_o & ~IER_MASK) == '0);

    assert_no_enable_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_o == '0) |-> !irq_o);

    assert_susp_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_o[B_EOT] && status_o[B_SUSP]) |-> irq_o);

    assert_txtf_autoclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        txtf_ev_i |=> (ier_o[B_DXP] == 1'b0 && ier_o[B_TXP] == 1'b0));

    assert_modf_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[B_MODF] |-> (xfer_abort_o && !tx_dma_req_o && !rx_dma_req_o));

    assert_ovr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_ev_i |=> rx_drop_o);

    assert_txdma_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !txdma_en_i |-> !tx_dma_req_o);
endmodule

bind spi_stat_irq_unit spi_stat_irq_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_pkt_i     (rx_pkt_i),
    .tx_space_i   (tx_space_i),
    .eot_ev_i     (eot_ev_i),
    .modf_ev_i    (modf_ev_i),
    .ovr_ev_i     (ovr_ev_i),
    .txtf_ev_i    (txtf_ev_i),
    .clr_we_i     (clr_we_i),
    .clr_wdata_i  (clr_wdata_i),
    .txdma_en_i   (txdma_en_i),
    .status_o     (status_o),
    .ier_o        (ier_o),
    .irq_o        (irq_o),
    .tx_dma_req_o (tx_dma_req_o),
    .rx_dma_req_o (rx_dma_req_o),
    .xfer_abort_o (xfer_abort_o),
    .rx_drop_o    (rx_drop_o)
);

// File: tb/spi_stat_irq_unit_bench.sv
// Self-checking bench for spi_stat_irq_unit. Starts with a vector table, then runs directed tests.
module spi_stat_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_pkt_i = 0, tx_space_i = 0, rx_word_ne_i = 0;
    logic [1:0]  rx_part_lvl_i = 0;
    logic        eot_ev_i = 0, susp_ev_i = 0, txc_ev_i = 0;
    logic        txtf_ev_i = 0, ovr_ev_i = 0, modf_ev_i = 0;
    logic        ier_we_i = 0, clr_we_i = 0;
    logic [15:0] ier_wdata_i = 0, clr_wdata_i = 0;
    logic        txdma_en_i = 0, rxdma_en_i = 0;
    logic [15:0] status_o, ier_o;
    logic        irq_o, tx_dma_req_o, rx_dma_req_o, xfer_abort_o, rx_drop_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [15:0] STICKY = 16'h0A78;

    // Table fields: ier[37:22] rxp[21] txp[20] lvl[19:18] wne[17] exp_status[16:1] exp_irq[0]
    localparam int NV = 8;
    localparam logic [37:0] VEC [NV] = '{
        {16'h0000, 1'b1, 1'b0, 2'b00, 1'b0, 16'h0001, 1'b0},
        {16'h0001, 1'b1, 1'b0, 2'b00, 1'b0, 16'h0001, 1'b1},
        {16'h0002, 1'b1, 1'b0, 2'b00, 1'b0, 16'h0001, 1'b0},
        {16'h0002, 1'b0, 1'b1, 2'b00, 1'b0, 16'h0002, 1'b1},
        {16'h0004, 1'b1, 1'b1, 2'b10, 1'b1, 16'hC007, 1'b1},
        {16'h0004, 1'b1, 1'b0, 2'b01, 1'b0, 16'h2001, 1'b0},
        {16'hFFFF, 1'b0, 1'b0, 2'b11, 1'b1, 16'hE000, 1'b0},
        {16'h0008, 1'b1, 1'b1, 2'b00, 1'b0, 16'h0007, 1'b0}
    };

    spi_stat_irq_unit u_spi_stat_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .rx_pkt_i(rx_pkt_i), .tx_space_i(tx_space_i),
        .rx_part_lvl_i(rx_part_lvl_i), .rx_word_ne_i(rx_word_ne_i),
        .eot_ev_i(eot_ev_i), .susp_ev_i(susp_ev_i), .txc_ev_i(txc_ev_i),
        .txtf_ev_i(txtf_ev_i), .ovr_ev_i(ovr_ev_i), .modf_ev_i(modf_ev_i),
        .ier_we_i(ier_we_i), .ier_wdata_i(ier_wdata_i),
        .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
        .txdma_en_i(txdma_en_i), .rxdma_en_i(rxdma_en_i),
        .status_o(status_o), .ier_o(ier_o), .irq_o(irq_o),
        .tx_dma_req_o(tx_dma_req_o), .rx_dma_req_o(rx_dma_req_o),
        .xfer_abort_o(xfer_abort_o), .rx_drop_o(rx_drop_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ier(input logic [15:0] v);
        @(negedge clk); ier_we_i = 1'b1; ier_wdata_i = v;
        @(negedge clk); ier_we_i = 1'b0;
    endtask

    task automatic wr_clr(input logic [15:0] v);
        @(negedge clk); clr_we_i = 1'b1; clr_wdata_i = v;
        @(negedge clk); clr_we_i = 1'b0;
    endtask

    task automatic set_ev(input int k, input logic v);
        case (k)
            0: eot_ev_i  = v;
            1: txtf_ev_i = v;
            2: txc_ev_i  = v;
            3: ovr_ev_i  = v;
            4: modf_ev_i = v;
            default: susp_ev_i = v;
        endcase
    endtask

    task automatic pulse(input int k);
        @(negedge clk); set_ev(k, 1'b1);
        @(negedge clk); set_ev(k, 1'b0);
    endtask

    function automatic logic [15:0] ev_bit(input int k);
        case (k)
            0: return 16'h0008;
            1: return 16'h0010;
            2: return 16'h0020;
            3: return 16'h0040;
            4: return 16'h0200;
            default: return 16'h0800;
        endcase
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: outputs while reset is still held
        @(negedge clk);
        chk("R1 ier", 32'(ier_o), 0);
        chk("R1 status", 32'(status_o), 0);
        chk("R1 outs", {28'd0, irq_o, xfer_abort_o, rx_drop_o, tx_dma_req_o}, 0);
        rst_n = 1'b1;

        // Vector table: levels, enables and interrupt (R2, R5, R6)
        for (int i = 0; i < NV; i++) begin
            wr_ier(VEC[i][37:22]);
            rx_pkt_i = VEC[i][21]; tx_space_i = VEC[i][20];
            rx_part_lvl_i = VEC[i][19:18]; rx_word_ne_i = VEC[i][17];
            #1;
            chk($sformatf("R2 status vec%0d", i), 32'(status_o), 32'(VEC[i][16:1]));
            chk($sformatf("R6 irq vec%0d", i), 32'(irq_o), 32'(VEC[i][0]));
        end
        rx_pkt_i = 0; tx_space_i = 0; rx_part_lvl_i = 0; rx_word_ne_i = 0;

        // R5: unsupported enable bits read 0
        wr_ier(16'hFFFF);
        chk("R5 ier readback", 32'(ier_o), 32'h025F);
        wr_ier(16'h0000);

        // R3 and R4: each event sets its own flag; a clear write removes it
        for (int k = 0; k < 6; k++) begin
            pulse(k);
            chk($sformatf("R3 set ev%0d", k), 32'(status_o & STICKY), 32'(ev_bit(k)));
            wr_clr(ev_bit(k));
            chk($sformatf("R4 clr ev%0d", k), 32'(status_o & STICKY), 0);
        end

        // R4: bits written with zero keep their flag
        pulse(0); pulse(3);
        wr_clr(16'h0008);
        chk("R4 partial clear", 32'(status_o & STICKY), 32'h0040);
        wr_clr(16'h0040);

        // R4: an event wins over a clear in the same cycle
        pulse(0);
        @(negedge clk); eot_ev_i = 1; clr_we_i = 1; clr_wdata_i = 16'h0008;
        @(negedge clk); eot_ev_i = 0; clr_we_i = 0;
        chk("R4 set wins", 32'(status_o[3]), 1);
        wr_clr(16'h0008);

        // R2: a clear write does not touch the level bits
        rx_pkt_i = 1; tx_space_i = 1; rx_word_ne_i = 1;
        wr_clr(16'hFFFF);
        #1;
        chk("R2 levels survive clear", 32'(status_o), 32'h8007);
        rx_pkt_i = 0; tx_space_i = 0; rx_word_ne_i = 0;

        // R6: one shared enable covers end of transfer, suspend and transmission complete
        wr_ier(16'h0008);
        chk("R6 quiet", 32'(irq_o), 0);
        pulse(5);
        chk("R6 suspend irq", 32'(irq_o), 1);
        wr_clr(16'h0800);
        chk("R6 suspend cleared", 32'(irq_o), 0);
        pulse(2);
        chk("R6 txc irq", 32'(irq_o), 1);
        wr_clr(16'h0020);
        pulse(0);
        chk("R6 eot irq", 32'(irq_o), 1);
        wr_clr(16'h0008);
        wr_ier(16'h0200);
        pulse(4);
        chk("R6 modf irq", 32'(irq_o), 1);
        wr_clr(16'h0200);
        chk("R6 modf cleared", 32'(irq_o), 0);

        // R7: a transfer-filled event drops enable bits 1 and 2 only
        wr_ier(16'h025F);
        pulse(1);
        chk("R7 auto clear", 32'(ier_o), 32'h0259);
        chk("R6 txtf irq", 32'(irq_o), 1);
        wr_clr(16'h0010);
        // R7: the auto-clear overrides an enable write in the same cycle
        @(negedge clk); ier_we_i = 1; ier_wdata_i = 16'h0006; txtf_ev_i = 1;
        @(negedge clk); ier_we_i = 0; txtf_ev_i = 0;
        chk("R7 beats write", 32'(ier_o), 0);
        wr_clr(16'h0010);

        // R10 and R8: DMA gating and the mode-fault block
        rx_pkt_i = 1; tx_space_i = 1; txdma_en_i = 1; rxdma_en_i = 1;
        #1;
        chk("R10 both requests", {30'd0, tx_dma_req_o, rx_dma_req_o}, 3);
        pulse(4);
        chk("R8 fault blocks", {29'd0, xfer_abort_o, tx_dma_req_o, rx_dma_req_o}, 32'h4);
        wr_clr(16'h0200);
        chk("R8 fault released", {29'd0, xfer_abort_o, tx_dma_req_o, rx_dma_req_o}, 32'h3);
        txdma_en_i = 0;
        #1;
        chk("R10 tx enable off", {30'd0, tx_dma_req_o, rx_dma_req_o}, 1);
        rx_pkt_i = 0;
        #1;
        chk("R10 rx level off", 32'(rx_dma_req_o), 0);
        rxdma_en_i = 0; tx_space_i = 0;

        // R9: the overrun flag drives the drop output
        pulse(3);
        chk("R9 drop on", 32'(rx_drop_o), 1);
        wr_clr(16'h0040);
        chk("R9 drop off", 32'(rx_drop_o), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule